// File: doc/BRIEF.md
# Transmit Descriptor Ring Activity Controller

This block decides whether a transmit datapath is currently working through a ring of transmit descriptors. It watches a transmit-enable command bit, the produce and consume indices of the ring, a busy level from the datapath and an acknowledge pulse that says a frame's status has been written back to memory. From these it keeps a two-state register: idle or running. The running state is shown on `tx_active`. On the cycle the controller enters the running state it raises `fetch_start` for exactly one cycle, so that a descriptor fetcher can begin.

The controller enters the running state only when it is enabled and the ring holds work, meaning the two indices differ. It falls back to idle at once when the ring drains, meaning the indices become equal. When the enable is withdrawn it stays running until the datapath is no longer busy and the status of the last finished frame has been acknowledged. A soft reset acts like the hardware reset. After either reset, the enable must be seen low once before the controller can start again.

Top module: `txact_ctrl`

## Requirements
- R1: While reset is applied, and after it, `tx_active` and `fetch_start` are 0.
- R2: From idle, a clock edge with `tx_en`=1 and `prod_idx`!=`cons_idx` (and no re-arm hold) moves the controller to running. `tx_active` is 1 from the cycle after that edge.
- R3: The index comparison uses all IDX_W bits. Indices that differ only in the most significant bit count as differing.
- R4: In running, a clock edge with `prod_idx`==`cons_idx` returns the controller to idle, whatever the values of `tx_en`, `dp_busy` and `stat_ack`.
- R5: In running, a clock edge with `tx_en`=0, `dp_busy`=0 and no status owed returns the controller to idle.
- R6: A status is owed from the cycle `dp_busy` falls (1 to 0) until `stat_ack`=1. An ack in the same cycle as the fall settles it. While busy or owed, `tx_en`=0 keeps the controller running.
- R7: `fetch_start` is 1 for exactly the one cycle in which `tx_active` first shows 1 after an entry, and 0 at all other times.
- R8: A clock edge with `soft_rst`=1 forces idle, clears the owed status and blocks re-entry until `tx_en`=0 has been seen at a clock edge. Hardware reset sets the same block.
- R9: With `tx_en`=0, pending ring work does not start the controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| soft_rst | input | 1 | Synchronous soft reset, same effect as hardware reset |
| tx_en | input | 1 | Transmit enable command bit |
| prod_idx | input | IDX_W | Ring produce index |
| cons_idx | input | IDX_W | Ring consume index |
| dp_busy | input | 1 | Datapath is transmitting a frame |
| stat_ack | input | 1 | Status of the last finished frame has been written back |
| tx_active | output | 1 | 1 while running, 0 while idle |
| fetch_start | output | 1 | One-cycle pulse on each entry to running |

## Verification
The bench drops the enable while a frame is in flight. It then holds off the acknowledge after busy falls, and separately gives the acknowledge in the very cycle busy falls. A design that ignores the owed status would go idle too early. A design that misses the same-cycle acknowledge would stay running for good. It drains the ring while the datapath is still busy, to show that drain wins over busy. It also uses indices that differ only in their top bit, which catches a truncated comparator. After a soft reset it keeps the enable high: a design without the re-arm hold would restart at once, and one that keeps `fetch_start` high for more than one cycle is caught by the per-cycle scoreboard.

// File: rtl/txact_pkg.sv
package txact_pkg;
  typedef enum logic {
    RING_IDLE = 1'b0,
    RING_RUN  = 1'b1
  } ring_state_t;
endpackage

// File: rtl/txact_rst_sync.sv
module txact_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/txact_idx_cmp.sv
module txact_idx_cmp #(
  parameter int IDX_W = 16
) (
  input  logic [IDX_W-1:0] prod_idx,
  input  logic [IDX_W-1:0] cons_idx,
  output logic             ring_pending
);
  logic [IDX_W-1:0] diff_bits;

  genvar gi;
  generate
    for (gi = 0; gi < IDX_W; gi++) begin : g_bit
      assign diff_bits[gi] = prod_idx[gi] ^ cons_idx[gi];
    end
  endgenerate

  assign ring_pending = |diff_bits;
endmodule

// File: rtl/txact_drain_mon.sv
module txact_drain_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic dp_busy,
  input  logic stat_ack,
  output logic quiet
);
  logic busy_q, owed_q;
  logic busy_fell, owed_d;

  always_comb begin
    busy_fell = busy_q & ~dp_busy;
    owed_d    = (owed_q | busy_fell) & ~stat_ack;
    quiet     = ~dp_busy & ~owed_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      owed_q <= 1'b0;
    end else if (clr) begin
      busy_q <= 1'b0;
      owed_q <= 1'b0;
    end else begin
      busy_q <= dp_busy;
      owed_q <= owed_d;
    end
  end

  AST_OWED_CLEARS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_ack && !clr) |=> !owed_q); // R6
endmodule

// File: rtl/txact_rearm.sv
module txact_rearm (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic tx_en,
  output logic hold
);
  logic hold_q, hold_d, hold_ce;

  always_comb begin
    hold_ce = soft_rst | ~tx_en;
    hold_d  = soft_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= 1'b1;
    else if (hold_ce) hold_q <= hold_d;
  end

  assign hold = hold_q;

  AST_HOLD_RELEASE_NEEDS_LOW_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> $past(!tx_en)); // R8
endmodule

// File: rtl/txact_ctrl.sv
module txact_ctrl #(
  parameter int IDX_W     = 16,
  parameter int RST_STAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             tx_en,
  input  logic [IDX_W-1:0] prod_idx,
  input  logic [IDX_W-1:0] cons_idx,
  input  logic             dp_busy,
  input  logic             stat_ack,
  output logic             tx_active,
  output logic             fetch_start
);
  import txact_pkg::*;

  logic        rst_sync_n;
  logic        ring_pending;
  logic        quiet;
  logic        hold;
  ring_state_t state_q, state_d;
  logic        start_q, start_d;
  logic        enter;

  txact_rst_sync #(.STAGES(RST_STAGE)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  txact_idx_cmp #(.IDX_W(IDX_W)) u_idx_cmp (
    .prod_idx     (prod_idx),
    .cons_idx     (cons_idx),
    .ring_pending (ring_pending)
  );

  txact_drain_mon u_drain_mon (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (soft_rst),
    .dp_busy  (dp_busy),
    .stat_ack (stat_ack),
    .quiet    (quiet)
  );

  txact_rearm u_rearm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .soft_rst (soft_rst),
    .tx_en    (tx_en),
    .hold     (hold)
  );

  always_comb begin
    enter   = 1'b0;
    state_d = state_q;
    if (soft_rst) begin
      state_d = RING_IDLE;
    end else begin
      unique case (state_q)
        RING_IDLE: begin
          if (tx_en && ring_pending && !hold) begin
            state_d = RING_RUN;
            enter   = 1'b1;
          end
        end
        RING_RUN: begin
          if (!ring_pending)       state_d = RING_IDLE;
          else if (!tx_en && quiet) state_d = RING_IDLE;
        end
        default: state_d = RING_IDLE;
      endcase
    end
    start_d = enter;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= RING_IDLE;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
    end
  end

  assign tx_active   = (state_q == RING_RUN);
  assign fetch_start = start_q;

  AST_START_ONLY_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fetch_start |-> (tx_active && !$past(tx_active))); // R7
  AST_ENTRY_NEEDS_WORK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(tx_active) |-> $past(tx_en && (prod_idx != cons_idx))); // R2
  AST_DRAIN_EXIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_active && (prod_idx == cons_idx)) |=> !tx_active); // R4
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_active && dp_busy && (prod_idx != cons_idx) && !soft_rst) |=> tx_active); // R6
  AST_SOFT_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    soft_rst |=> (!tx_active && !fetch_start)); // R8
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!tx_active && !tx_en) |=> !tx_active); // R9
endmodule

// File: tb/txact_ctrl_tb.sv
module txact_ctrl_tb;
  localparam int IDX_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             soft_rst;
  logic             tx_en;
  logic [IDX_W-1:0] prod_idx;
  logic [IDX_W-1:0] cons_idx;
  logic             dp_busy;
  logic             stat_ack;
  logic             tx_active;
  logic             fetch_start;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic  act;
    logic  start;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  txact_ctrl #(.IDX_W(IDX_W)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .tx_en       (tx_en),
    .prod_idx    (prod_idx),
    .cons_idx    (cons_idx),
    .dp_busy     (dp_busy),
    .stat_ack    (stat_ack),
    .tx_active   (tx_active),
    .fetch_start (fetch_start)
  );

  task automatic compare(input logic act, input logic start, input string tag);
    checks++;
    if (tx_active !== act || fetch_start !== start) begin
      errors++;
      $display("FAIL %s: got active=%b start=%b, expected active=%b start=%b",
               tag, tx_active, fetch_start, act, start);
    end
  endtask

  task automatic step(input logic sr, input logic en, input logic [IDX_W-1:0] p,
                      input logic [IDX_W-1:0] c, input logic b, input logic a,
                      input logic exp_act, input logic exp_start, input string tag);
    exp_t e;
    @(negedge clk);
    soft_rst = sr; tx_en = en; prod_idx = p; cons_idx = c; dp_busy = b; stat_ack = a;
    e.act = exp_act; e.start = exp_start; e.tag = tag;
    sb_q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        compare(e.act, e.start, e.tag);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0; soft_rst = 1'b0; tx_en = 1'b0; prod_idx = '0; cons_idx = '0;
    dp_busy = 1'b0; stat_ack = 1'b0;
    repeat (3) @(posedge clk);
    #1 compare(1'b0, 1'b0, "R1 during reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 compare(1'b0, 1'b0, "R1 after reset");

    // R9: work pending but disabled
    step(0, 0, 16'd3, 16'd0, 0, 0, 0, 0, "R9 disabled no start");
    step(0, 0, 16'd3, 16'd0, 0, 0, 0, 0, "R9 still idle");
    // R2 / R7 entry
    step(0, 1, 16'd3, 16'd0, 0, 0, 1, 1, "R2 entry with start R7");
    step(0, 1, 16'd3, 16'd0, 0, 0, 1, 0, "R7 start one cycle");
    // R6: disable while busy, then status owed
    step(0, 0, 16'd3, 16'd0, 1, 0, 1, 0, "R6 busy keeps running");
    step(0, 0, 16'd3, 16'd0, 0, 0, 1, 0, "R6 busy fell, status owed");
    step(0, 0, 16'd3, 16'd0, 0, 0, 1, 0, "R6 still owed");
    step(0, 0, 16'd3, 16'd0, 0, 1, 0, 0, "R6 ack releases, R5 exit");
    step(0, 0, 16'd3, 16'd0, 0, 0, 0, 0, "R9 stays idle");
    // R5 plain disable
    step(0, 1, 16'd3, 16'd0, 0, 0, 1, 1, "R2 re-entry R7");
    step(0, 0, 16'd3, 16'd0, 0, 0, 0, 0, "R5 disable exit when quiet");
    // R6 ack in same cycle as busy fall
    step(0, 1, 16'd3, 16'd0, 0, 0, 1, 1, "R2 entry again");
    step(0, 1, 16'd3, 16'd0, 1, 0, 1, 0, "R6 busy");
    step(0, 0, 16'd3, 16'd0, 0, 1, 0, 0, "R6 same-cycle ack exit");
    // R4 drain wins over busy
    step(0, 1, 16'd3, 16'd0, 0, 0, 1, 1, "R2 entry for drain");
    step(0, 1, 16'd3, 16'd0, 1, 0, 1, 0, "R4 busy running");
    step(0, 1, 16'd3, 16'd3, 1, 0, 0, 0, "R4 drain exit while busy");
    step(0, 1, 16'd3, 16'd3, 0, 1, 0, 0, "R4 stays idle when equal");
    // R3 top-bit difference
    step(0, 1, 16'h8000, 16'h0000, 0, 0, 1, 1, "R3 msb-only difference starts");
    step(0, 1, 16'h8000, 16'h0000, 0, 0, 1, 0, "R3 running");
    step(0, 1, 16'h8000, 16'h8000, 0, 0, 0, 0, "R3 equal full width drains");
    // R8 soft reset and re-arm
    step(0, 1, 16'd5, 16'd0, 0, 0, 1, 1, "R2 entry before soft reset");
    step(1, 1, 16'd5, 16'd0, 0, 0, 0, 0, "R8 soft reset forces idle");
    step(0, 1, 16'd5, 16'd0, 0, 0, 0, 0, "R8 held off with enable high");
    step(0, 1, 16'd5, 16'd0, 0, 0, 0, 0, "R8 still held off");
    step(0, 0, 16'd5, 16'd0, 0, 0, 0, 0, "R8 enable low rearms");
    step(0, 1, 16'd5, 16'd0, 0, 0, 1, 1, "R8 restart after rearm");
    step(0, 1, 16'd5, 16'd5, 0, 0, 0, 0, "R4 final drain");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule